// File: doc/BRIEF.md
# Two-Wire Bus Interrupt and Clock-Stretch Timer

This block follows the serial clock of a two-wire bus, counts the clocks of each byte and decides at which falling clock edge the local controller is interrupted and the bus is stalled. It stalls the bus by pulling the clock line low. Software ends the stall by pulsing a release strobe. The block works in both the master and the slave role. It drives the acknowledge bit for the slave side when the slave is addressed.

The point where the block interrupts depends on the role and on the phase of the transfer. For data bytes, one select bit picks the eighth or the ninth clock. For address bytes the point is fixed at the ninth clock. When a slave sees a reserved extension pattern, the point moves to the eighth clock. A slave that is not addressed stays quiet, except after a repeated start: then it raises the interrupt but does not stall the bus. The inputs are the clock and data samples, already synchronized to the system clock, and the start and stop strobes come from a separate bus-condition detector.

Top module: `i2c_irq_wait_ctrl`

## Requirements
- R1: `irq` is a single-cycle pulse. It rises in the system cycle after a counted falling edge of `scl_in` and never at any other time.
- R2: For a data byte with `wait_sel`=0, `irq` and `scl_hold` are raised at the falling edge of clock 8. This holds for the master role and for an addressed slave, both when receiving and when transmitting.
- R3: For a data byte with `wait_sel`=1, `irq` and `scl_hold` are raised at the falling edge of clock 9.
- R4: In the master role, an address byte raises `irq` and `scl_hold` at the falling edge of clock 9, whatever the value of `wait_sel`.
- R5: In the slave role, an address byte whose first seven bits match `own_addr` raises `irq` and `scl_hold` at the falling edge of clock 9, whatever the value of `wait_sel`. The bus sends the most significant bit first, and the eighth bit is the direction bit.
- R6: On a slave address match, `ack_drive` is high for the whole of clock 9 even when `ack_en`=0. The signal is set at the falling edge of clock 8 and cleared at the falling edge of clock 9.
- R7: In the slave role, an address byte whose upper five bits are 11110 raises `irq` and `scl_hold` at the falling edge of clock 8.
- R8: In the slave role, an address byte that does not match and is not an extension code raises no `irq` and no `scl_hold`. This holds during that byte and during the data bytes that follow it.
- R9: In the slave role, a non-matching address after a repeated start (a start with no stop since the previous start) raises `irq` at clock 9 but no `scl_hold`.
- R10: Once set, `scl_hold` stays high until a `release_pulse`. It is low in the cycle after that pulse.
- R11: A `stop_pulse` clears `scl_hold` and `ack_drive` and returns the block to idle. In idle, clock edges raise no `irq`. After reset all outputs are low.
- R12: An addressed slave that receives data drives `ack_drive` during clock 9 only when `ack_en`=1.
- R13: A start strobe restarts the clock count. A falling edge of `scl_in` that has no rising edge after the start is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronized clock line sample |
| sda_in | input | 1 | Synchronized data line sample |
| start_pulse | input | 1 | Start or repeated-start strobe |
| stop_pulse | input | 1 | Stop strobe |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| is_tx | input | 1 | 1 = local side transmits data bytes |
| wait_sel | input | 1 | Data-byte point select: 0 = clock 8, 1 = clock 9 |
| ack_en | input | 1 | Acknowledge enable for received data |
| own_addr | input | ADDR_W | Own slave address |
| release_pulse | input | 1 | Software strobe that ends a stall |
| irq | output | 1 | Interrupt request pulse |
| scl_hold | output | 1 | Pull the clock line low |
| ack_drive | output | 1 | Drive the acknowledge bit low on the data line |

## Verification
The assertions check on every cycle that the interrupt appears only right after a counted falling clock edge and lasts one cycle. They also check that a stall starts only together with an interrupt, that a stall persists until a release, start or stop, that a stop clears the stall and the acknowledge, that the clock count stays in range, and that the acknowledge is driven only in the slave role. Only the bench scenarios can show at which clock number the interrupt lands for each role, phase and select value. The same holds for address matching, extension codes, the repeated-start case without a stall, and the acknowledge behaviour under `ack_en`.

// File: rtl/i2c_iw_pkg.sv
package i2c_iw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  localparam int EXT_BITS = 5;
  localparam logic [EXT_BITS-1:0] EXT_PATTERN = 5'b11110;
endpackage

// File: rtl/iw_scl_edge.sv
module iw_scl_edge (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  output logic rise,
  output logic fall
);
  logic scl_d;

  always_ff @(posedge clk) begin
    if (rst) scl_d <= 1'b1;
    else     scl_d <= scl_in;
  end

  assign rise = ~scl_d & scl_in;
  assign fall = scl_d & ~scl_in;
endmodule

// File: rtl/iw_bit_track.sv
module iw_bit_track #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_pulse,
  input  logic              stop_pulse,
  input  logic              rise,
  input  logic              fall,
  input  logic              sda_in,
  output logic              fall_ok,
  output logic [CNT_W-1:0]  clk_num,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [DATA_W-1:0] shreg
);
  localparam logic [CNT_W-1:0] LAST_M1 = CNT_W'(DATA_W);

  logic armed;

  assign fall_ok = fall & armed;
  assign clk_num = bit_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || start_pulse || stop_pulse) begin
      bit_cnt <= '0;
      armed   <= 1'b0;
      if (rst) shreg <= '0;
    end else begin
      if (rise) begin
        armed <= 1'b1;
        shreg <= {shreg[DATA_W-2:0], sda_in};
      end
      if (fall_ok) begin
        armed   <= 1'b0;
        bit_cnt <= (bit_cnt == LAST_M1) ? '0 : bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/iw_addr_dec.sv
module iw_addr_dec #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              hit,
  output logic              ext
);
  import i2c_iw_pkg::*;

  assign hit = rx_byte[DATA_W-1 -: ADDR_W] == own_addr;
  assign ext = rx_byte[DATA_W-1 -: EXT_BITS] == EXT_PATTERN;
endmodule

// File: rtl/i2c_irq_wait_ctrl.sv
module i2c_irq_wait_ctrl #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              start_pulse,
  input  logic              stop_pulse,
  input  logic              is_master,
  input  logic              is_tx,
  input  logic              wait_sel,
  input  logic              ack_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              release_pulse,
  output logic              irq,
  output logic              scl_hold,
  output logic              ack_drive
);
  import i2c_iw_pkg::*;

  localparam logic [CNT_W-1:0] N_BYTE = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] N_LAST = CNT_W'(DATA_W + 1);

  logic              scl_rise, scl_fall, fall_ok;
  logic [CNT_W-1:0]  clk_num, bit_cnt;
  logic [DATA_W-1:0] rx_byte;
  logic              addr_hit, addr_ext;
  logic [CNT_W-1:0]  data_point;

  phase_e phase;
  logic   rep_start, addressed, ext_seen;

  iw_scl_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .scl_in (scl_in),
    .rise   (scl_rise),
    .fall   (scl_fall)
  );

  iw_bit_track #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_track (
    .clk         (clk),
    .rst         (rst),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .rise        (scl_rise),
    .fall        (scl_fall),
    .sda_in      (sda_in),
    .fall_ok     (fall_ok),
    .clk_num     (clk_num),
    .bit_cnt     (bit_cnt),
    .shreg       (rx_byte)
  );

  iw_addr_dec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .rx_byte  (rx_byte),
    .own_addr (own_addr),
    .hit      (addr_hit),
    .ext      (addr_ext)
  );

  assign data_point = wait_sel ? N_LAST : N_BYTE;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      rep_start <= 1'b0;
      addressed <= 1'b0;
      ext_seen  <= 1'b0;
      irq       <= 1'b0;
      scl_hold  <= 1'b0;
      ack_drive <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (stop_pulse) begin
        phase     <= PH_IDLE;
        rep_start <= 1'b0;
        addressed <= 1'b0;
        ext_seen  <= 1'b0;
        scl_hold  <= 1'b0;
        ack_drive <= 1'b0;
      end else if (start_pulse) begin
        rep_start <= (phase != PH_IDLE);
        phase     <= PH_ADDR;
        addressed <= 1'b0;
        ext_seen  <= 1'b0;
        scl_hold  <= 1'b0;
        ack_drive <= 1'b0;
      end else begin
        if (release_pulse) scl_hold <= 1'b0;
        if (fall_ok && phase != PH_IDLE) begin
          if (clk_num == N_LAST) begin
            ack_drive <= 1'b0;
            phase     <= PH_DATA;
          end
          if (phase == PH_ADDR) begin
            if (is_master) begin
              if (clk_num == N_LAST) begin
                irq      <= 1'b1;
                scl_hold <= 1'b1;
              end
            end else begin
              if (clk_num == N_BYTE) begin
                if (addr_ext) begin
                  irq       <= 1'b1;
                  scl_hold  <= 1'b1;
                  addressed <= 1'b1;
                  ext_seen  <= 1'b1;
                end else if (addr_hit) begin
                  addressed <= 1'b1;
                  ack_drive <= 1'b1;
                end
              end
              if (clk_num == N_LAST) begin
                if (addressed && !ext_seen) begin
                  irq      <= 1'b1;
                  scl_hold <= 1'b1;
                end else if (!addressed && rep_start) begin
                  irq <= 1'b1;
                end
              end
            end
          end else begin
            if ((is_master || addressed) && clk_num == data_point) begin
              irq      <= 1'b1;
              scl_hold <= 1'b1;
            end
            if (clk_num == N_BYTE && !is_master && addressed && !is_tx && ack_en)
              ack_drive <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/iw_chk.sv
module iw_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             fall_ok,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             irq,
  input logic             scl_hold,
  input logic             ack_drive,
  input logic             is_master,
  input logic             release_pulse,
  input logic             start_pulse,
  input logic             stop_pulse
);
  AST_IRQ_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(fall_ok)); // R1
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R1
  AST_HOLD_NEEDS_IRQ: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_hold) |-> irq); // R10
  AST_HOLD_PERSISTS: assert property (@(posedge clk) disable iff (rst)
    ($past(scl_hold) && !$past(release_pulse) && !$past(stop_pulse) && !$past(start_pulse))
      |-> scl_hold); // R10
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(stop_pulse) |-> (!scl_hold && !ack_drive)); // R11
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(DATA_W)); // R13
  AST_ACK_SLAVE_ONLY: assert property (@(posedge clk) disable iff (rst)
    ack_drive |-> !is_master); // R6
endmodule

bind i2c_irq_wait_ctrl iw_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_iw_chk (
  .clk           (clk),
  .rst           (rst),
  .fall_ok       (fall_ok),
  .bit_cnt       (bit_cnt),
  .irq           (irq),
  .scl_hold      (scl_hold),
  .ack_drive     (ack_drive),
  .is_master     (is_master),
  .release_pulse (release_pulse),
  .start_pulse   (start_pulse),
  .stop_pulse    (stop_pulse)
);

// File: tb/i2c_irq_wait_ctrl_bench.sv
`timescale 1ns/1ps
module i2c_irq_wait_ctrl_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic start_pulse = 1'b0, stop_pulse = 1'b0;
  logic is_master = 1'b0, is_tx = 1'b0, wait_sel = 1'b0, ack_en = 1'b0;
  logic [6:0] own_addr = 7'h2A;
  logic release_pulse = 1'b0;
  logic irq, scl_hold, ack_drive;

  int checks = 0, errors = 0;
  int bus_clk = 0, irq_n = 0, irq_at = 0, hold_n = 0, hold_at = 0, ack_seen = 0;
  bit auto_rel = 1'b1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_irq_wait_ctrl u_i2c_irq_wait_ctrl (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .is_master(is_master), .is_tx(is_tx), .wait_sel(wait_sel), .ack_en(ack_en),
    .own_addr(own_addr), .release_pulse(release_pulse),
    .irq(irq), .scl_hold(scl_hold), .ack_drive(ack_drive)
  );

  always @(negedge clk) begin
    if (!rst && irq) begin
      irq_n  = irq_n + 1;
      irq_at = bus_clk;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_bit(input logic b, input int idx);
    sda_in = b;
    repeat (2) @(negedge clk);
    scl_in = 1'b1;
    repeat (2) @(negedge clk);
    if (idx == 9 && ack_drive) ack_seen = 1;
    @(negedge clk);
    scl_in  = 1'b0;
    bus_clk = idx;
    repeat (3) @(negedge clk);
    if (scl_hold) begin
      hold_n++;
      hold_at = idx;
      if (auto_rel) begin
        repeat (6) @(negedge clk);
        chk("R10 hold kept", scl_hold, 1);
        release_pulse = 1'b1;
        @(negedge clk);
        release_pulse = 1'b0;
        chk("R10 hold released", scl_hold, 0);
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic nine);
    irq_n = 0; irq_at = 0; hold_n = 0; hold_at = 0; ack_seen = 0;
    for (int i = 0; i < 9; i++) bus_bit((i < 8) ? b[7-i] : nine, i + 1);
  endtask

  task automatic do_start();
    sda_in = 1'b1;
    scl_in = 1'b1;
    repeat (3) @(negedge clk);
    start_pulse = 1'b1;
    @(negedge clk);
    start_pulse = 1'b0;
    sda_in = 1'b0;
    @(negedge clk);
    scl_in = 1'b0;
    repeat (3) @(negedge clk);
    bus_clk = 0;
  endtask

  task automatic do_stop();
    sda_in = 1'b0;
    scl_in = 1'b1;
    repeat (3) @(negedge clk);
    stop_pulse = 1'b1;
    @(negedge clk);
    stop_pulse = 1'b0;
    sda_in = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 reset irq", irq, 0);
    chk("R11 reset hold", scl_hold, 0);
    chk("R11 reset ack", ack_drive, 0);
  endtask

  task automatic t_master();
    is_master = 1'b1; wait_sel = 1'b0;
    do_start();
    send_byte(8'hA0, 1'b0);
    chk("R4 addr irq count", irq_n, 1);
    chk("R4 addr irq clock", irq_at, 9);
    chk("R4 addr hold clock", hold_at, 9);
    chk("R1 no ack in master", ack_seen, 0);
    send_byte(8'h5A, 1'b0);
    chk("R2 master data irq count", irq_n, 1);
    chk("R2 master data irq clock", irq_at, 8);
    chk("R2 master data hold clock", hold_at, 8);
    wait_sel = 1'b1;
    send_byte(8'hC3, 1'b0);
    chk("R3 master data irq clock", irq_at, 9);
    chk("R3 master data hold clock", hold_at, 9);
    do_start();
    send_byte(8'hA1, 1'b0);
    chk("R4 addr after restart sel1", irq_at, 9);
    chk("R4 addr hold count", hold_n, 1);
    do_stop();
  endtask

  task automatic t_slave_match();
    is_master = 1'b0; is_tx = 1'b0; wait_sel = 1'b0; ack_en = 1'b0;
    do_start();
    send_byte(8'h54, 1'b0);
    chk("R5 match irq count", irq_n, 1);
    chk("R5 match irq clock", irq_at, 9);
    chk("R5 match hold clock", hold_at, 9);
    chk("R6 forced ack", ack_seen, 1);
    ack_en = 1'b1;
    send_byte(8'h3C, 1'b1);
    chk("R2 slave rx irq clock", irq_at, 8);
    chk("R2 slave rx hold clock", hold_at, 8);
    chk("R12 ack with enable", ack_seen, 1);
    ack_en = 1'b0; wait_sel = 1'b1;
    send_byte(8'h99, 1'b1);
    chk("R3 slave rx irq clock", irq_at, 9);
    chk("R12 no ack without enable", ack_seen, 0);
    do_stop();
    chk("R11 ack cleared by stop", ack_drive, 0);
    send_byte(8'h54, 1'b1);
    chk("R11 idle irq count", irq_n, 0);
    chk("R11 idle hold count", hold_n, 0);
  endtask

  task automatic t_ext();
    is_master = 1'b0; wait_sel = 1'b1;
    do_start();
    send_byte(8'hF6, 1'b1);
    chk("R7 ext irq count", irq_n, 1);
    chk("R7 ext irq clock", irq_at, 8);
    chk("R7 ext hold clock", hold_at, 8);
    do_stop();
  endtask

  task automatic t_mismatch();
    is_master = 1'b0; wait_sel = 1'b0; ack_en = 1'b1;
    do_start();
    send_byte(8'h22, 1'b1);
    chk("R8 mismatch irq count", irq_n, 0);
    chk("R8 mismatch hold count", hold_n, 0);
    chk("R8 mismatch no ack", ack_seen, 0);
    send_byte(8'h11, 1'b1);
    chk("R8 data after mismatch irq", irq_n, 0);
    do_start();
    send_byte(8'h22, 1'b1);
    chk("R9 restart mismatch irq count", irq_n, 1);
    chk("R9 restart mismatch irq clock", irq_at, 9);
    chk("R9 restart mismatch no hold", hold_n, 0);
    do_stop();
    ack_en = 1'b0;
  endtask

  task automatic t_stop_hold();
    is_master = 1'b1; wait_sel = 1'b0;
    auto_rel = 1'b0;
    do_start();
    send_byte(8'hB0, 1'b0);
    repeat (20) @(negedge clk);
    chk("R10 hold without release", scl_hold, 1);
    do_stop();
    chk("R11 stop clears hold", scl_hold, 0);
    auto_rel = 1'b1;
  endtask

  task automatic t_restart_mid();
    is_master = 1'b1; wait_sel = 1'b0;
    do_start();
    for (int i = 0; i < 4; i++) bus_bit(1'b1, i + 1);
    do_start();
    send_byte(8'h90, 1'b0);
    chk("R13 count restarts irq count", irq_n, 1);
    chk("R13 count restarts irq clock", irq_at, 9);
    do_stop();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_master();
    t_slave_match();
    t_ext();
    t_mismatch();
    t_stop_hold();
    t_restart_mid();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule